// File: doc/BRIEF.md
# UART Interrupt Request Combiner

This block merges the interrupt conditions of a UART into one active-low request line for the processor. Four conditions come from status flags: transmit register empty, transmitter idle, receive data available and receive overrun. Each flag passes through an enable mask. The two transmit conditions each have their own enable. The two receive conditions share one enable. Two more conditions have no flag. The first is an address frame: a received frame whose ninth bit is set, accepted only while address detection is enabled. The second is a wake event: a falling edge on the raw RX pin while the UART clock is off and both the wake enable and the receive enable are set.

The request is a one-clock low pulse on `irq_n`. It fires when any enabled condition rises. A condition that stays high does not fire again. The status flags are inputs here, and the block never clears them. A wake edge is caught by a latch clocked by the RX pin itself, so it is caught even while the UART clock is stopped. The latch passes through a synchronizer. Its request is held back while `clk_off` is high. The latch is released once a pulse has been issued for it.

The pulse generator is a three-state machine. IDLE goes to FIRE on any rising enabled condition. FIRE always goes to GAP, and `irq_n` is low only in FIRE. GAP goes back to FIRE if a rise arrived during FIRE or arrives in GAP; otherwise it goes to IDLE. A rise that arrives in FIRE is held in a pending bit until GAP serves it.

Top module: `uart_irq_combiner`

## Requirements
- R1: While reset is active and after it is released with every input idle (flags low, `rx_pin` high), `irq_n` is high.
- R2: When `tx_empty` rises while `en_tx_empty` is 1, `irq_n` is low for exactly one clock, in the cycle after the clock edge that samples the rise. With `en_tx_empty` at 0, `tx_empty` causes no pulse.
- R3: `tx_idle` is masked only by `en_tx_idle`. Setting `en_tx_empty` alone does not let `tx_idle` cause a pulse.
- R4: `rx_avail` and `rx_overrun` are both masked by the single enable `en_rx`. Each fires a pulse when it rises while `en_rx` is 1, and neither fires while `en_rx` is 0.
- R5: A one-cycle `frame_done` strobe with `frame_bit9` = 1 fires a pulse when `en_addr` is 1. With `frame_bit9` = 0 or `en_addr` = 0 there is no pulse.
- R6: A falling edge on `rx_pin` while `clk_off`, `en_wake` and `en_rx` are all 1 is captured. No pulse is issued while `clk_off` stays 1. Exactly one pulse follows within a few clocks after `clk_off` returns to 0. The capture is then released, so a later wake edge fires again.
- R7: A falling edge on `rx_pin` while `clk_off` is 0, or while `en_wake` is 0, never produces a pulse.
- R8: An enabled condition held high for many cycles produces only one pulse.
- R9: No pulse is ever longer than one clock. Two sources rising on consecutive clocks give two separate pulses, with at least one high cycle between them.
- R10: Setting an enable while its flag is already high counts as a rising condition and fires one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | UART clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_empty | input | 1 | Transmit register empty flag |
| tx_idle | input | 1 | Transmitter idle flag |
| rx_avail | input | 1 | Receive data available flag |
| rx_overrun | input | 1 | Receive overrun flag |
| frame_done | input | 1 | One-cycle strobe: a frame was received |
| frame_bit9 | input | 1 | Ninth (address marker) bit of that frame |
| rx_pin | input | 1 | Raw RX line, idle high |
| clk_off | input | 1 | High while the UART clock source is switched off |
| en_tx_empty | input | 1 | Enable for transmit empty |
| en_tx_idle | input | 1 | Enable for transmitter idle |
| en_rx | input | 1 | Shared enable for receive available and overrun; also arms wake |
| en_addr | input | 1 | Address detection enable |
| en_wake | input | 1 | RX-pin wake enable |
| irq_n | output | 1 | Active-low interrupt request pulse |

## Verification
Each internal fault shows up at `irq_n` within a clock or two.

| Fault | What `irq_n` shows |
|---|---|
| State machine stuck in FIRE | A low level lasting two or more samples, seen on the very next sample |
| Edge register lost or wrong | A held flag fires every cycle, or a rising flag never fires, within one cycle of the stimulus |
| Pending bit dropped | The second of two back-to-back rises gives no pulse, seen two cycles after the first rise |
| Wake latch never released | The second wake sequence gives no pulse, a few clocks after `clk_off` falls |
| Wake latch not masked by `clk_off` | A pulse while `clk_off` is still high |

// File: rtl/uirq_pkg.sv
package uirq_pkg;
    localparam int NUM_SRC  = 6;
    localparam int SRC_TXE  = 0;
    localparam int SRC_TXI  = 1;
    localparam int SRC_RXA  = 2;
    localparam int SRC_OVR  = 3;
    localparam int SRC_ADDR = 4;
    localparam int SRC_WAKE = 5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FIRE = 2'd1,
        ST_GAP  = 2'd2
    } irq_state_e;
endpackage

// File: rtl/uirq_edge_bank.sv
module uirq_edge_bank #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cond,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_src
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q[i] <= 1'b0;
            else        prev_q[i] <= cond[i];
        end
        assign rise[i] = cond[i] & ~prev_q[i];
    end

    // a rise is never reported two cycles running for the same source (R8)
    p_no_repeat_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        |rise |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/uirq_wake_catch.sv
module uirq_wake_catch #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_pin,
    input  logic clk_off,
    input  logic arm,
    input  logic fire_now,
    output logic wake_req
);
    localparam int LAST = SYNC_STAGES - 1;

    logic                   caught_q;
    logic                   ack_q;
    logic                   clr;
    logic [SYNC_STAGES-1:0] sync_q;

    assign clr = ack_q | ~rst_n;

    // capture flop clocked by the pin itself, works with the UART clock stopped
    always_ff @(negedge rx_pin or posedge clr) begin
        if (clr)      caught_q <= 1'b0;
        else if (arm) caught_q <= 1'b1;
    end

    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q[s] <= 1'b0;
            else        sync_q[s] <= (s == 0) ? caught_q : sync_q[(s == 0) ? 0 : s-1];
        end
    end

    assign wake_req = sync_q[LAST] & ~clk_off;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    ack_q <= 1'b0;
        else if (wake_req && fire_now) ack_q <= 1'b1;
        else if (!sync_q[LAST])        ack_q <= 1'b0;
    end

    // release only after a pulse was issued with the clock running (R6)
    p_release_after_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_q) |-> $past(fire_now && wake_req));
    // no wake request escapes while the clock is off (R6)
    p_hold_while_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clk_off |-> !wake_req);
endmodule

// File: rtl/uart_irq_combiner.sv
module uart_irq_combiner
    import uirq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_empty,
    input  logic tx_idle,
    input  logic rx_avail,
    input  logic rx_overrun,
    input  logic frame_done,
    input  logic frame_bit9,
    input  logic rx_pin,
    input  logic clk_off,
    input  logic en_tx_empty,
    input  logic en_tx_idle,
    input  logic en_rx,
    input  logic en_addr,
    input  logic en_wake,
    output logic irq_n
);
    logic [NUM_SRC-1:0] cond;
    logic [NUM_SRC-1:0] rise;
    logic               rise_any;
    logic               wake_req;
    logic               pend_q;
    irq_state_e         state_q, state_nx;

    always_comb begin
        cond           = '0;
        cond[SRC_TXE]  = tx_empty   & en_tx_empty;
        cond[SRC_TXI]  = tx_idle    & en_tx_idle;
        cond[SRC_RXA]  = rx_avail   & en_rx;
        cond[SRC_OVR]  = rx_overrun & en_rx;
        cond[SRC_ADDR] = frame_done & frame_bit9 & en_addr;
        cond[SRC_WAKE] = wake_req;
    end

    uirq_edge_bank #(.N(NUM_SRC)) u_edges (
        .clk   (clk),
        .rst_n (rst_n),
        .cond  (cond),
        .rise  (rise)
    );

    uirq_wake_catch #(.SYNC_STAGES(SYNC_STAGES)) u_wake (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_pin   (rx_pin),
        .clk_off  (clk_off),
        .arm      (clk_off & en_wake & en_rx),
        .fire_now (state_q == ST_FIRE),
        .wake_req (wake_req)
    );

    assign rise_any = |rise;

    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: if (rise_any) state_nx = ST_FIRE;
            ST_FIRE: state_nx = ST_GAP;
            ST_GAP:  state_nx = (rise_any || pend_q) ? ST_FIRE : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_nx;
            if (state_q == ST_FIRE && rise_any) pend_q <= 1'b1;
            else if (state_nx == ST_FIRE)       pend_q <= 1'b0;
        end
    end

    always_comb begin
        irq_n = (state_q != ST_FIRE);
    end

    // pulse never lasts more than one clock (R9)
    p_one_clock_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |=> irq_n);
    // an idle machine answers a rise on the next clock (R2)
    p_rise_fires_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && rise_any) |=> !irq_n);
    // no pulse without a cause (R8)
    p_pulse_has_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> $past(rise_any || pend_q));
    // a rise held back during FIRE is served from GAP (R9)
    p_pending_served_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_GAP && pend_q) |=> !irq_n);
endmodule

// File: tb/uart_irq_combiner_test.sv
module uart_irq_combiner_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_empty = 0, tx_idle = 0, rx_avail = 0, rx_overrun = 0;
    logic frame_done = 0, frame_bit9 = 0, rx_pin = 1, clk_off = 0;
    logic en_tx_empty = 0, en_tx_idle = 0, en_rx = 0, en_addr = 0, en_wake = 0;
    logic irq_n;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    int long_lows = 0;
    bit prev_low = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    uart_irq_combiner uut (
        .clk(clk), .rst_n(rst_n), .tx_empty(tx_empty), .tx_idle(tx_idle),
        .rx_avail(rx_avail), .rx_overrun(rx_overrun), .frame_done(frame_done),
        .frame_bit9(frame_bit9), .rx_pin(rx_pin), .clk_off(clk_off),
        .en_tx_empty(en_tx_empty), .en_tx_idle(en_tx_idle), .en_rx(en_rx),
        .en_addr(en_addr), .en_wake(en_wake), .irq_n(irq_n)
    );

    always @(negedge clk) begin
        if (rst_n && irq_n === 1'b0) begin
            if (prev_low) long_lows++;
            else          pulses++;
        end
        prev_low = rst_n && (irq_n === 1'b0);
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_pulses(input int base, input int exp, input string req);
        check(pulses - base == exp, req, pulses - base, exp);
    endtask

    task automatic t_reset();
        int b;
        check(irq_n === 1'b1, "R1 during reset", int'(irq_n), 1);
        run(2);
        rst_n = 1'b1;
        b = pulses;
        run(5);
        check(irq_n === 1'b1, "R1 after reset", int'(irq_n), 1);
        expect_pulses(b, 0, "R1 no pulse");
    endtask

    task automatic t_tx_empty();
        int b;
        b = pulses;
        en_tx_empty = 1; tx_empty = 1;
        run(1);
        check(irq_n === 1'b0, "R2 low one cycle after rise", int'(irq_n), 0);
        run(1);
        check(irq_n === 1'b1, "R2 high again", int'(irq_n), 1);
        run(10);
        expect_pulses(b, 1, "R8 held flag single pulse");
        tx_empty = 0; en_tx_empty = 0;
        run(2);
        b = pulses;
        tx_empty = 1;
        run(6);
        expect_pulses(b, 0, "R2 masked");
        tx_empty = 0;
        run(2);
    endtask

    task automatic t_tx_idle();
        int b;
        b = pulses;
        en_tx_empty = 1; tx_idle = 1;
        run(6);
        expect_pulses(b, 0, "R3 wrong enable");
        en_tx_empty = 0;
        b = pulses;
        en_tx_idle = 1;
        run(6);
        expect_pulses(b, 1, "R10 enable with flag high");
        tx_idle = 0; en_tx_idle = 0;
        run(2);
    endtask

    task automatic t_rx_shared();
        int b;
        en_rx = 1;
        b = pulses;
        rx_avail = 1;
        run(5);
        expect_pulses(b, 1, "R4 rx_avail");
        rx_avail = 0;
        b = pulses;
        rx_overrun = 1;
        run(5);
        expect_pulses(b, 1, "R4 rx_overrun");
        rx_overrun = 0; en_rx = 0;
        run(2);
        b = pulses;
        rx_avail = 1;
        run(2);
        rx_overrun = 1;
        run(4);
        expect_pulses(b, 0, "R4 shared enable off");
        rx_avail = 0; rx_overrun = 0;
        run(2);
    endtask

    task automatic strobe_frame(input bit b9);
        frame_bit9 = b9; frame_done = 1;
        run(1);
        frame_done = 0; frame_bit9 = 0;
        run(5);
    endtask

    task automatic t_addr();
        int b;
        en_addr = 1;
        b = pulses;
        strobe_frame(1'b1);
        expect_pulses(b, 1, "R5 address frame");
        b = pulses;
        strobe_frame(1'b0);
        expect_pulses(b, 0, "R5 data frame");
        en_addr = 0;
        b = pulses;
        strobe_frame(1'b1);
        expect_pulses(b, 0, "R5 detection off");
    endtask

    task automatic t_back2back();
        int b, l;
        b = pulses; l = long_lows;
        en_tx_empty = 1; en_tx_idle = 1;
        tx_empty = 1;
        run(1);
        tx_idle = 1;
        run(8);
        expect_pulses(b, 2, "R9 two pulses");
        check(long_lows - l == 0, "R9 pulse width", long_lows - l, 0);
        tx_empty = 0; tx_idle = 0; en_tx_empty = 0; en_tx_idle = 0;
        run(2);
    endtask

    task automatic wake_once(input string req);
        int b;
        en_wake = 1; en_rx = 1; clk_off = 1;
        run(2);
        b = pulses;
        rx_pin = 0;
        run(6);
        expect_pulses(b, 0, "R6 held while clock off");
        clk_off = 0;
        run(10);
        expect_pulses(b, 1, req);
        rx_pin = 1;
        run(4);
    endtask

    task automatic t_wake();
        wake_once("R6 wake pulse");
        wake_once("R6 released, second wake");
        en_wake = 0; en_rx = 0;
        run(2);
    endtask

    task automatic t_wake_ignored();
        int b;
        b = pulses;
        en_wake = 1; en_rx = 1; clk_off = 0;
        run(1);
        rx_pin = 0;
        run(8);
        rx_pin = 1;
        expect_pulses(b, 0, "R7 clock running");
        en_wake = 0; clk_off = 1;
        run(2);
        rx_pin = 0;
        run(4);
        clk_off = 0;
        run(8);
        rx_pin = 1;
        expect_pulses(b, 0, "R7 wake disabled");
        en_rx = 0;
        run(2);
    endtask

    initial begin
        t_reset();
        t_tx_empty();
        t_tx_idle();
        t_rx_shared();
        t_addr();
        t_back2back();
        t_wake();
        t_wake_ignored();
        check(long_lows == 0, "R9 no long pulse overall", long_lows, 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule